// File: doc/BRIEF.md
# Byte-wide ALU with decimal correction

This block is a purely combinational arithmetic and logic unit for an 8-bit accumulator datapath. A 4-bit operation code selects one of fourteen functions: binary add and subtract, with or without the incoming carry, and compare; bitwise AND, OR and XOR; increment and decrement of the operand; decimal correction of the accumulator after a BCD add or subtract; one's complement of the accumulator; and set or toggle of the carry flag. It returns a result byte and a new flag byte.

The flag byte carries zero (Z) in bit 7, subtract (N) in bit 6, half-carry (H) in bit 5 and carry (C) in bit 4. The low four bits of the flag output are always zero. The surrounding core supplies the accumulator, the second operand and the current flag byte, then writes back whichever of the result and flags its instruction needs. A compare returns the accumulator unchanged as its result.

Top module: `byte_alu`

## Requirements
- R1: Op 0 (add) returns acc+opnd mod 256, clears N, sets H when the low nibbles sum above 0xF, sets C when the full sum exceeds 0xFF, and sets Z when the result is zero.
- R2: Op 1 (add with carry) behaves as op 0 but adds the incoming C (flags_i bit 4) into both the nibble sum and the full sum.
- R3: Op 2 (subtract) and op 7 (compare) set N, set H on a borrow out of the low nibble, set C when opnd exceeds acc, and set Z when acc-opnd is zero; op 2 returns the difference and op 7 returns acc unchanged.
- R4: Op 3 (subtract with borrow) behaves as op 2 but also subtracts the incoming C in both the nibble and the full borrow tests.
- R5: Ops 4 (AND), 5 (XOR) and 6 (OR) return the bitwise result, clear N and C, set H for AND only and clear it for XOR and OR, and set Z on a zero result.
- R6: Op 8 (increment) returns opnd+1 mod 256, clears N, sets H when the result's low nibble is 0, sets Z on zero, and copies the incoming C.
- R7: Op 9 (decrement) returns opnd-1 mod 256, sets N, sets H when the result's low nibble is 0xF, sets Z on zero, and copies the incoming C.
- R8: Op 10 (decimal adjust) first adds 0x06 to acc (subtracts it when incoming N is 1) if incoming H is 1 or acc's low nibble is above 9; then, if the high nibble of that value is above 9, adds 0x60 (subtracts when N is 1) and sets C, otherwise clears C; N is kept, H is cleared and Z reflects the result.
- R9: Op 11 (complement) returns ~acc, sets N and H, and keeps Z and C.
- R10: Op 12 sets C and op 13 inverts C; both clear N and H, keep Z, and return acc.
- R11: Bits 3..0 of flags_o are always 0; ops 14 and 15 return acc and copy flags_i bits 7..4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand, or the value for increment/decrement |
| flags_i | input | 8 | Current flags: Z bit 7, N bit 6, H bit 5, C bit 4 |
| res_o | output | 8 | Result byte |
| flags_o | output | 8 | New flags, same layout, low nibble zero |

## Verification
The in-line assertions check, for every input combination the bench presents, the relations that hold across the whole operation space: increment and decrement never alter carry, compare always returns the accumulator, subtract-class operations always set N, logic operations always clear carry, decimal adjust always clears H, Z always agrees with a written result, and the flag low nibble stays zero. The exact numeric values of H and C at nibble and byte boundaries, the two-stage decimal correction in both add and subtract directions, and the pass-through of the reserved codes can only be shown by the bench's directed scenarios and its comparison against an independent integer model.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int ALU_W = 8;
  localparam int NIB_W = ALU_W / 2;
  localparam int FLAG_LO_W = ALU_W - 4;

  typedef logic [ALU_W-1:0] word_t;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_CP   = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_DAA  = 4'd10,
    OP_CPL  = 4'd11,
    OP_SCF  = 4'd12,
    OP_CCF  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flag_t;

  typedef struct packed {
    word_t val;
    logic  half;
    logic  full;
  } span_t;

  // Sum with carry in; half is the carry out of the low nibble.
  function automatic span_t nib_add(word_t a, word_t b, logic cin);
    logic [NIB_W:0] lo;
    logic [ALU_W:0] all;
    lo  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    all = {1'b0, a} + {1'b0, b} + {{ALU_W{1'b0}}, cin};
    return '{val: all[ALU_W-1:0], half: lo[NIB_W], full: all[ALU_W]};
  endfunction

  // Difference with borrow in; half is the borrow out of the low nibble.
  function automatic span_t nib_sub(word_t a, word_t b, logic bin);
    logic [NIB_W:0] lo;
    logic [ALU_W:0] all;
    lo  = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, bin};
    all = {1'b0, a} - {1'b0, b} - {{ALU_W{1'b0}}, bin};
    return '{val: all[ALU_W-1:0], half: lo[NIB_W], full: all[ALU_W]};
  endfunction

  function automatic flag_t unpack_flags(word_t f);
    return '{z: f[7], n: f[6], h: f[5], c: f[4]};
  endfunction

  function automatic word_t pack_flags(flag_t f);
    return {f.z, f.n, f.h, f.c, {FLAG_LO_W{1'b0}}};
  endfunction
endpackage

// File: rtl/byte_alu_arith.sv
module byte_alu_arith
  import byte_alu_pkg::*;
(
  input  alu_op_e op,
  input  word_t   a,
  input  word_t   b,
  input  flag_t   fin,
  output word_t   res,
  output flag_t   fout,
  output logic    hit
);
  span_t s;

  always_comb begin
    s    = '0;
    res  = a;
    fout = fin;
    hit  = 1'b1;
    unique case (op)
      OP_ADD, OP_ADC: begin
        s    = nib_add(a, b, (op == OP_ADC) ? fin.c : 1'b0);
        res  = s.val;
        fout = '{z: (s.val == '0), n: 1'b0, h: s.half, c: s.full};
      end
      OP_SUB, OP_SBC, OP_CP: begin
        s    = nib_sub(a, b, (op == OP_SBC) ? fin.c : 1'b0);
        res  = (op == OP_CP) ? a : s.val;
        fout = '{z: (s.val == '0), n: 1'b1, h: s.half, c: s.full};
      end
      OP_INC: begin
        s    = nib_add(b, word_t'(1), 1'b0);
        res  = s.val;
        fout = '{z: (s.val == '0), n: 1'b0, h: s.half, c: fin.c};
      end
      OP_DEC: begin
        s    = nib_sub(b, word_t'(1), 1'b0);
        res  = s.val;
        fout = '{z: (s.val == '0), n: 1'b1, h: s.half, c: fin.c};
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
  import byte_alu_pkg::*;
(
  input  alu_op_e op,
  input  word_t   a,
  input  word_t   b,
  input  flag_t   fin,
  output word_t   res,
  output flag_t   fout,
  output logic    hit
);
  word_t bw;

  always_comb begin
    bw   = '0;
    res  = a;
    fout = fin;
    hit  = 1'b1;
    unique case (op)
      OP_AND, OP_XOR, OP_OR: begin
        if (op == OP_AND)      bw = a & b;
        else if (op == OP_XOR) bw = a ^ b;
        else                   bw = a | b;
        res  = bw;
        fout = '{z: (bw == '0), n: 1'b0, h: (op == OP_AND), c: 1'b0};
      end
      OP_CPL: begin
        res  = ~a;
        fout = '{z: fin.z, n: 1'b1, h: 1'b1, c: fin.c};
      end
      OP_SCF, OP_CCF: begin
        fout = '{z: fin.z, n: 1'b0, h: 1'b0, c: (op == OP_SCF) ? 1'b1 : ~fin.c};
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/byte_alu_bcd.sv
module byte_alu_bcd
  import byte_alu_pkg::*;
(
  input  alu_op_e op,
  input  word_t   a,
  input  logic    sub_i,
  input  logic    half_i,
  output word_t   res,
  output flag_t   fout,
  output logic    hit
);
  localparam word_t LO_FIX = word_t'(8'h06);
  localparam word_t HI_FIX = word_t'(8'h60);
  localparam int    DIGIT_MAX = 9;

  word_t stage1;
  word_t stage2;
  logic  lo_fix;
  logic  hi_fix;

  always_comb begin
    lo_fix = half_i || (int'(a[NIB_W-1:0]) > DIGIT_MAX);
    stage1 = a;
    if (lo_fix) stage1 = sub_i ? (a - LO_FIX) : (a + LO_FIX);
    hi_fix = int'(stage1[ALU_W-1:NIB_W]) > DIGIT_MAX;
    stage2 = stage1;
    if (hi_fix) stage2 = sub_i ? (stage1 - HI_FIX) : (stage1 + HI_FIX);
  end

  assign hit  = (op == OP_DAA);
  assign res  = stage2;
  assign fout = '{z: (stage2 == '0), n: sub_i, h: 1'b0, c: hi_fix};
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic [7:0] flags_i,
  output logic [7:0] res_o,
  output logic [7:0] flags_o
);
  alu_op_e op;
  flag_t   fin;
  flag_t   fsel;

  word_t ar_res, lg_res, bc_res;
  flag_t ar_f, lg_f, bc_f;
  logic  ar_hit, lg_hit, bc_hit;

  assign op  = alu_op_e'(op_i);
  assign fin = unpack_flags(flags_i);

  byte_alu_arith u_arith (
    .op(op), .a(acc_i), .b(opnd_i), .fin(fin),
    .res(ar_res), .fout(ar_f), .hit(ar_hit)
  );

  byte_alu_logic u_logic (
    .op(op), .a(acc_i), .b(opnd_i), .fin(fin),
    .res(lg_res), .fout(lg_f), .hit(lg_hit)
  );

  byte_alu_bcd u_bcd (
    .op(op), .a(acc_i), .sub_i(fin.n), .half_i(fin.h),
    .res(bc_res), .fout(bc_f), .hit(bc_hit)
  );

  always_comb begin
    if (ar_hit) begin
      res_o = ar_res;
      fsel  = ar_f;
    end else if (lg_hit) begin
      res_o = lg_res;
      fsel  = lg_f;
    end else if (bc_hit) begin
      res_o = bc_res;
      fsel  = bc_f;
    end else begin
      res_o = acc_i;
      fsel  = fin;
    end
  end

  assign flags_o = pack_flags(fsel);

  // Cross-unit checks on the selected outputs.
  always_comb begin
    if (!$isunknown({op_i, acc_i, opnd_i, flags_i})) begin
      assert_one_unit_R11: assert ($countones({ar_hit, lg_hit, bc_hit}) <= 1)
        else $error("more than one unit claims the op");
      assert_flag_lo_zero_R11: assert (flags_o[3:0] == 4'b0000)
        else $error("flag low nibble not zero");
      if (op == OP_INC || op == OP_DEC)
        assert_step_keeps_c_R6: assert (flags_o[4] == flags_i[4])
          else $error("inc/dec altered carry");
      if (op == OP_CP)
        assert_cp_keeps_acc_R3: assert (res_o == acc_i)
          else $error("compare changed result");
      if (op == OP_SUB || op == OP_SBC || op == OP_CP || op == OP_DEC || op == OP_CPL)
        assert_sub_sets_n_R3: assert (flags_o[6])
          else $error("N not set");
      if (op == OP_AND || op == OP_XOR || op == OP_OR)
        assert_logic_c_clear_R5: assert (!flags_o[4] && !flags_o[6])
          else $error("logic op left N or C");
      if (op == OP_DAA)
        assert_daa_h_clear_R8: assert (!flags_o[5] && flags_o[6] == flags_i[6])
          else $error("decimal adjust H/N wrong");
      if (op == OP_ADD || op == OP_ADC || op == OP_SUB || op == OP_SBC ||
          op == OP_AND || op == OP_XOR || op == OP_OR || op == OP_INC ||
          op == OP_DEC || op == OP_DAA)
        assert_zero_tracks_R1: assert (flags_o[7] == (res_o == 8'h00))
          else $error("Z disagrees with result");
      if (op == OP_SCF || op == OP_CCF || op == OP_CPL)
        assert_keep_z_R10: assert (flags_o[7] == flags_i[7] && res_o == (op == OP_CPL ? ~acc_i : acc_i))
          else $error("flag op altered Z or result");
    end
  end
endmodule

// File: tb/sim_byte_alu.sv
module sim_byte_alu;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] acc_i = 8'h00;
  logic [7:0] opnd_i = 8'h00;
  logic [7:0] flags_i = 8'h00;
  logic [7:0] res_o;
  logic [7:0] flags_o;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  byte_alu u0 (
    .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i), .flags_i(flags_i),
    .res_o(res_o), .flags_o(flags_o)
  );

  // Independent integer model: returns {result, flags}.
  function automatic logic [15:0] model(int op, int a, int x, int f);
    int z, n, h, c, r, ci, s, v;
    z = (f >> 7) & 1; n = (f >> 6) & 1; h = (f >> 5) & 1; c = (f >> 4) & 1;
    r = a;
    case (op)
      0, 1: begin
        ci = (op == 1) ? c : 0;
        s = a + x + ci;
        h = ((a % 16) + (x % 16) + ci) > 15;
        c = s > 255; r = s % 256; n = 0; z = (r == 0);
      end
      2, 3, 7: begin
        ci = (op == 3) ? c : 0;
        h = (a % 16) < (x % 16) + ci;
        c = a < x + ci;
        r = (a - x - ci + 512) % 256; n = 1; z = (r == 0);
        if (op == 7) r = a;
      end
      4: begin r = a & x; z = (r == 0); n = 0; h = 1; c = 0; end
      5: begin r = a ^ x; z = (r == 0); n = 0; h = 0; c = 0; end
      6: begin r = a | x; z = (r == 0); n = 0; h = 0; c = 0; end
      8: begin r = (x + 1) % 256; n = 0; h = (r % 16) == 0; z = (r == 0); end
      9: begin r = (x + 255) % 256; n = 1; h = (r % 16) == 15; z = (r == 0); end
      10: begin
        v = a;
        if (h == 1 || (a % 16) > 9) v = (n == 1) ? v - 6 : v + 6;
        v = (v + 256) % 256;
        c = 0;
        if ((v / 16) > 9) begin
          v = (n == 1) ? v - 96 : v + 96;
          c = 1;
        end
        r = (v + 256) % 256; h = 0; z = (r == 0);
      end
      11: begin r = 255 - a; n = 1; h = 1; end
      12: begin n = 0; h = 0; c = 1; end
      13: begin n = 0; h = 0; c = 1 - c; end
      default: ;
    endcase
    model = {r[7:0], z[0], n[0], h[0], c[0], 4'b0000};
  endfunction

  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] x,
                       input logic [7:0] f);
    @(negedge clk);
    op_i = op; acc_i = a; opnd_i = x; flags_i = f;
    #1;
  endtask

  task automatic expect_out(input string req, input logic [7:0] er, input logic [7:0] ef);
    n_checks++;
    if (res_o !== er || flags_o !== ef) begin
      n_fails++;
      $display("FAIL %s op=%0d a=%02h x=%02h f=%02h: got res=%02h flags=%02h, expected res=%02h flags=%02h",
               req, op_i, acc_i, opnd_i, flags_i, res_o, flags_o, er, ef);
    end
  endtask

  task automatic t_reset_state();
    wait (rst_n);
    apply(4'd0, 8'h00, 8'h00, 8'h00);
    expect_out("R1 reset", 8'h00, 8'h80);
  endtask

  task automatic t_add();
    apply(4'd0, 8'h0F, 8'h01, 8'h00); expect_out("R1 nibble carry", 8'h10, 8'h20);
    apply(4'd0, 8'hFF, 8'h01, 8'h40); expect_out("R1 wrap", 8'h00, 8'hB0);
    apply(4'd0, 8'h80, 8'h80, 8'h10); expect_out("R1 full carry", 8'h00, 8'h90);
    apply(4'd1, 8'h0E, 8'h01, 8'h10); expect_out("R2 carry in", 8'h10, 8'h20);
    apply(4'd1, 8'hFF, 8'h00, 8'h10); expect_out("R2 carry wrap", 8'h00, 8'hB0);
  endtask

  task automatic t_sub();
    apply(4'd2, 8'h10, 8'h01, 8'h00); expect_out("R3 nibble borrow", 8'h0F, 8'h60);
    apply(4'd2, 8'h01, 8'h02, 8'h00); expect_out("R3 full borrow", 8'hFF, 8'h70);
    apply(4'd2, 8'h42, 8'h42, 8'h30); expect_out("R3 zero", 8'h00, 8'hC0);
    apply(4'd7, 8'h05, 8'h07, 8'h00); expect_out("R3 compare", 8'h05, 8'h70);
    apply(4'd7, 8'h33, 8'h33, 8'h00); expect_out("R3 compare equal", 8'h33, 8'hC0);
    apply(4'd3, 8'h10, 8'h0F, 8'h10); expect_out("R4 borrow in", 8'h00, 8'hE0);
    apply(4'd3, 8'h00, 8'h00, 8'h10); expect_out("R4 borrow wrap", 8'hFF, 8'h70);
  endtask

  task automatic t_logic();
    apply(4'd4, 8'hF0, 8'h0F, 8'h10); expect_out("R5 and zero", 8'h00, 8'hA0);
    apply(4'd5, 8'hFF, 8'h0F, 8'hF0); expect_out("R5 xor", 8'hF0, 8'h00);
    apply(4'd6, 8'h00, 8'h00, 8'h70); expect_out("R5 or zero", 8'h00, 8'h80);
  endtask

  task automatic t_step();
    apply(4'd8, 8'h55, 8'h0F, 8'h10); expect_out("R6 inc half", 8'h10, 8'h30);
    apply(4'd8, 8'h55, 8'hFF, 8'h00); expect_out("R6 inc wrap", 8'h00, 8'hA0);
    apply(4'd9, 8'h55, 8'h10, 8'h10); expect_out("R7 dec half", 8'h0F, 8'h70);
    apply(4'd9, 8'h55, 8'h01, 8'h00); expect_out("R7 dec zero", 8'h00, 8'hC0);
  endtask

  task automatic t_daa();
    apply(4'd10, 8'h3C, 8'h00, 8'h00); expect_out("R8 low fix", 8'h42, 8'h00);
    apply(4'd10, 8'h9A, 8'h00, 8'h00); expect_out("R8 both fix", 8'h00, 8'h90);
    apply(4'd10, 8'h0D, 8'h00, 8'h60); expect_out("R8 subtract fix", 8'h07, 8'h40);
    apply(4'd10, 8'h21, 8'h00, 8'h20); expect_out("R8 half only", 8'h27, 8'h00);
  endtask

  task automatic t_flag_ops();
    apply(4'd11, 8'h5A, 8'h00, 8'h90); expect_out("R9 complement", 8'hA5, 8'hF0);
    apply(4'd12, 8'h12, 8'h00, 8'hE0); expect_out("R10 set carry", 8'h12, 8'h90);
    apply(4'd13, 8'h12, 8'h00, 8'h90); expect_out("R10 toggle off", 8'h12, 8'h80);
    apply(4'd13, 8'h12, 8'h00, 8'h00); expect_out("R10 toggle on", 8'h12, 8'h10);
    apply(4'd14, 8'h33, 8'hCC, 8'hA5); expect_out("R11 reserved 14", 8'h33, 8'hA0);
    apply(4'd15, 8'h81, 8'h7E, 8'h5F); expect_out("R11 reserved 15", 8'h81, 8'h50);
  endtask

  task automatic t_sweep();
    int seed = 32'h1234_5678;
    logic [15:0] e;
    for (int i = 0; i < 2000; i++) begin
      seed = seed * 1103515245 + 12345;
      apply(seed[3:0], seed[11:4], seed[19:12], seed[27:20]);
      e = model(int'(op_i), int'(acc_i), int'(opnd_i), int'(flags_i));
      expect_out("R1..model sweep", e[15:8], e[7:0]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
  end

  initial begin
    t_reset_state();
    t_add();
    t_sub();
    t_logic();
    t_step();
    t_daa();
    t_flag_ops();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule